// File: doc/BRIEF.md
# GPIO Port with Change Notification

This block is a 16-pin general-purpose I/O port. Software reaches it over a simple word-addressed register bus. It drives an output-enable and an output level toward each pad, and it brings the pad levels back through a synchronizer. Each pin can be configured as an input or an output, as push-pull or open-drain, and as digital or analog. Weak pull-up and pull-down enables are held in registers and passed straight to the pad ring. Pins marked analog read back as zero and produce no digital input or change events.

A change-notification unit watches every pin. It catches rising and falling edges with flops clocked by the pad itself, so edges are still recorded while the main clock is stopped. The recorded toggles are then synchronized into the clock domain. An edge on a pin that has notification enabled and is digital sets that pin's pending bit. A two-state interrupt machine raises `irq` while any pending bit is set:
- `IRQ_IDLE` moves to `IRQ_RAISED` on the **detect** transition, when the pending vector is non-zero.
- `IRQ_RAISED` returns to `IRQ_IDLE` on the **acknowledge** transition, when software has cleared every pending bit.

Top module: `gpio_cn_port`

## Requirements
- R1: After reset, direction and analog-select read 0xFFFF, and latch, open-drain, notify-enable, pull-up, pull-down and pending read 0. No pad is driven and `irq` is low.
- R2: Word offsets are 0x0 direction, 0x2 latch, 0x3 open-drain, 0x4 analog-select, 0x5 notify-enable, 0x6 pull-up and 0x7 pull-down. Each reads back the last value written. `pad_pu` and `pad_pd` equal the pull-up and pull-down registers.
- R3: A write to offset 0x1 (port) updates the latch. A read of 0x2 returns the latch, not the pin levels.
- R4: Pin i is driven (`pad_oe[i]`=1) when direction bit i is 0 and either open-drain bit i is 0 or latch bit i is 0. `pad_out[i]` equals latch bit i AND NOT open-drain bit i, so an open-drain pin never drives high.
- R5: A pin set as an output while its analog-select bit is 1 is still driven according to R4.
- R6: A read of offset 0x1 returns the pad levels after SYNC_STAGES rising clock edges, ANDed with NOT analog-select. `pin_din` carries the same masked value to on-chip peripherals.
- R7: Reads of offsets 0x9 through 0xF return 0.
- R8: A rising or falling edge on pin i sets pending bit i (offset 0x8) only if notify-enable bit i is 1 and analog-select bit i is 0.
- R9: The interrupt machine enters `IRQ_RAISED` one edge after pending becomes non-zero. It holds `irq` high until pending is all zero, then returns to `IRQ_IDLE` one edge later.
- R10: Writing offset 0x8 clears each pending bit whose write-data bit is 1 and leaves the other bits unchanged.
- R11: When an edge event and a clearing write hit the same pending bit in the same cycle, the bit stays set.
- R12: Pin edges that occur while the clock is stopped are recorded and set the pending bits once the clock runs again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register word offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational, 0 when no read |
| pad_in | input | 16 | Pad input levels |
| pad_oe | output | 16 | Per-pin pad output enable |
| pad_out | output | 16 | Per-pin pad output level |
| pad_pu | output | 16 | Weak pull-up enables |
| pad_pd | output | 16 | Weak pull-down enables |
| pin_din | output | 16 | Synchronized digital pin levels, analog pins forced to 0 |
| irq | output | 1 | Change-notification interrupt request |

## Verification
The pending register has two writers that can act in the same cycle: the synchronized edge event and the software write-one-to-clear. The bench toggles a pin between clock edges, counts the synchronizer edges to the cycle where the event reaches the pending register, and places a clearing write to that bit in exactly that cycle. A later read must show the bit still set, and an assertion checks the same priority whenever an event is present. Edge capture while the clock is stopped is provoked by holding the bench clock low while the pin toggles.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int ADDR_W = 4;

    typedef enum logic [ADDR_W-1:0] {
        A_DIR  = 4'h0,
        A_PORT = 4'h1,
        A_LAT  = 4'h2,
        A_ODC  = 4'h3,
        A_ANA  = 4'h4,
        A_CNE  = 4'h5,
        A_PUE  = 4'h6,
        A_PDE  = 4'h7,
        A_PND  = 4'h8
    } reg_addr_e;

    typedef enum logic {
        IRQ_IDLE   = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);
    logic [W-1:0] stg_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
        end else begin
            stg_q[0] <= d_in;
            for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
        end
    end

    assign d_out = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int N = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [N-1:0]      bus_wdata,
    output logic [N-1:0]      bus_rdata,
    input  logic [N-1:0]      port_val,
    input  logic [N-1:0]      pend,
    output logic [N-1:0]      dir_o,
    output logic [N-1:0]      lat_o,
    output logic [N-1:0]      odc_o,
    output logic [N-1:0]      ana_o,
    output logic [N-1:0]      cne_o,
    output logic [N-1:0]      pue_o,
    output logic [N-1:0]      pde_o,
    output logic [N-1:0]      pnd_clr_o
);
    logic [N-1:0] dir_q, lat_q, odc_q, ana_q, cne_q, pue_q, pde_q;
    reg_addr_e    sel;

    assign sel = reg_addr_e'(bus_addr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= '1;
            lat_q <= '0;
            odc_q <= '0;
            ana_q <= '1;
            cne_q <= '0;
            pue_q <= '0;
            pde_q <= '0;
        end else if (bus_wr) begin
            case (sel)
                A_DIR:        dir_q <= bus_wdata;
                A_PORT, A_LAT: lat_q <= bus_wdata;
                A_ODC:        odc_q <= bus_wdata;
                A_ANA:        ana_q <= bus_wdata;
                A_CNE:        cne_q <= bus_wdata;
                A_PUE:        pue_q <= bus_wdata;
                A_PDE:        pde_q <= bus_wdata;
                default:      ;
            endcase
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (sel)
                A_DIR:   bus_rdata = dir_q;
                A_PORT:  bus_rdata = port_val;
                A_LAT:   bus_rdata = lat_q;
                A_ODC:   bus_rdata = odc_q;
                A_ANA:   bus_rdata = ana_q;
                A_CNE:   bus_rdata = cne_q;
                A_PUE:   bus_rdata = pue_q;
                A_PDE:   bus_rdata = pde_q;
                A_PND:   bus_rdata = pend;
                default: bus_rdata = '0;
            endcase
        end
    end

    assign pnd_clr_o = (bus_wr && sel == A_PND) ? bus_wdata : '0;
    assign dir_o = dir_q;
    assign lat_o = lat_q;
    assign odc_o = odc_q;
    assign ana_o = ana_q;
    assign cne_o = cne_q;
    assign pue_o = pue_q;
    assign pde_o = pde_q;
endmodule

// File: rtl/gpio_pad.sv
module gpio_pad #(
    parameter int N           = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] dir,
    input  logic [N-1:0] lat,
    input  logic [N-1:0] odc,
    input  logic [N-1:0] ana,
    input  logic [N-1:0] pad_in,
    output logic [N-1:0] pad_oe,
    output logic [N-1:0] pad_out,
    output logic [N-1:0] port_val
);
    logic [N-1:0] pin_sync;

    gpio_sync #(.W(N), .STAGES(SYNC_STAGES)) u_in_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (pad_in),
        .d_out (pin_sync)
    );

    // open-drain pins release the pad instead of driving high
    assign pad_oe   = ~dir & (~odc | ~lat);
    assign pad_out  = lat & ~odc;
    assign port_val = pin_sync & ~ana;
endmodule

// File: rtl/gpio_cn.sv
module gpio_cn
    import gpio_pkg::*;
#(
    parameter int N           = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pad_in,
    input  logic [N-1:0] cne,
    input  logic [N-1:0] ana,
    input  logic [N-1:0] clr,
    output logic [N-1:0] pend,
    output logic         irq
);
    localparam int TW = 2 * N;

    logic [N-1:0]  rise_t, fall_t;
    logic [TW-1:0] tgl_s, tgl_d, tgl_chg;
    logic [N-1:0]  ev, pend_q;
    irq_state_e    state_q, state_nx;

    // edge capture clocked by the pins themselves, alive without clk
    for (genvar i = 0; i < N; i++) begin : g_edge
        logic r_q, f_q;
        always_ff @(posedge pad_in[i] or negedge rst_n) begin
            if (!rst_n) r_q <= 1'b0;
            else        r_q <= ~r_q;
        end
        always_ff @(negedge pad_in[i] or negedge rst_n) begin
            if (!rst_n) f_q <= 1'b0;
            else        f_q <= ~f_q;
        end
        assign rise_t[i] = r_q;
        assign fall_t[i] = f_q;
    end

    gpio_sync #(.W(TW), .STAGES(SYNC_STAGES)) u_tgl_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  ({fall_t, rise_t}),
        .d_out (tgl_s)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tgl_d <= '0;
        else        tgl_d <= tgl_s;
    end

    assign tgl_chg = tgl_s ^ tgl_d;
    assign ev      = (tgl_chg[N-1:0] | tgl_chg[TW-1:N]) & cne & ~ana;

    // set has priority over the software clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~clr) | ev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_IDLE;
        else        state_q <= state_nx;
    end

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            IRQ_IDLE:   state_nx = (|pend_q) ? IRQ_RAISED : IRQ_IDLE;
            IRQ_RAISED: state_nx = (|pend_q) ? IRQ_RAISED : IRQ_IDLE;
            default:    state_nx = IRQ_IDLE;
        endcase
    end

    always_comb begin
        irq = (state_q == IRQ_RAISED);
    end

    assign pend = pend_q;
endmodule

// File: rtl/gpio_cn_port.sv
module gpio_cn_port
    import gpio_pkg::*;
#(
    parameter int N           = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [N-1:0]      bus_wdata,
    output logic [N-1:0]      bus_rdata,
    input  logic [N-1:0]      pad_in,
    output logic [N-1:0]      pad_oe,
    output logic [N-1:0]      pad_out,
    output logic [N-1:0]      pad_pu,
    output logic [N-1:0]      pad_pd,
    output logic [N-1:0]      pin_din,
    output logic              irq
);
    logic [N-1:0] dir, lat, odc, ana, cne, pnd_clr, pend, port_val;

    gpio_regs #(.N(N)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .port_val  (port_val),
        .pend      (pend),
        .dir_o     (dir),
        .lat_o     (lat),
        .odc_o     (odc),
        .ana_o     (ana),
        .cne_o     (cne),
        .pue_o     (pad_pu),
        .pde_o     (pad_pd),
        .pnd_clr_o (pnd_clr)
    );

    gpio_pad #(.N(N), .SYNC_STAGES(SYNC_STAGES)) u_pad (
        .clk      (clk),
        .rst_n    (rst_n),
        .dir      (dir),
        .lat      (lat),
        .odc      (odc),
        .ana      (ana),
        .pad_in   (pad_in),
        .pad_oe   (pad_oe),
        .pad_out  (pad_out),
        .port_val (port_val)
    );

    gpio_cn #(.N(N), .SYNC_STAGES(SYNC_STAGES)) u_cn (
        .clk    (clk),
        .rst_n  (rst_n),
        .pad_in (pad_in),
        .cne    (cne),
        .ana    (ana),
        .clr    (pnd_clr),
        .pend   (pend),
        .irq    (irq)
    );

    assign pin_din = port_val;
endmodule

// File: rtl/gpio_cn_port_chk.sv
module gpio_cn_port_chk
    import gpio_pkg::*;
#(
    parameter int N = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [N-1:0]      bus_wdata,
    input logic [N-1:0]      bus_rdata,
    input logic [N-1:0]      ana,
    input logic [N-1:0]      pend,
    input logic [N-1:0]      ev,
    input logic              irq
);
    AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(pend != '0)); // R9
    AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && pend != '0) |=> irq); // R9
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_PND) |=> ((pend & $past(bus_wdata) & ~$past(ev)) == '0)); // R10
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (ev != '0) |=> ((pend & $past(ev)) == $past(ev))); // R11
    AST_ANALOG_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_PORT) |-> ((bus_rdata & ana) == '0)); // R6
endmodule

bind gpio_cn_port gpio_cn_port_chk #(.N(N)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .ana       (ana),
    .pend      (pend),
    .ev        (u_cn.ev),
    .irq       (irq)
);

// File: tb/gpio_cn_port_tb_top.sv
module gpio_cn_port_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    typedef struct {
        logic [3:0]  a;
        logic [15:0] d;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        clk_run = 1'b1;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [15:0] pad_in = '0;
    logic [15:0] pad_oe, pad_out, pad_pu, pad_pd, pin_din;
    logic        irq;

    int   n_chk = 0;
    int   n_err = 0;
    bit   done  = 0;
    exp_t exp_q[$];

    gpio_cn_port dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out),
        .pad_pu(pad_pu), .pad_pd(pad_pd), .pin_din(pin_din), .irq(irq)
    );

    // clock that can be parked low to model sleep
    initial begin
        forever begin
            #(CLK_PERIOD/2);
            if (clk_run || clk) clk = ~clk;
        end
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // driver tasks are entered right after a falling edge
    task automatic bus_write(input logic [3:0] a, input logic [15:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, input logic [15:0] d, input string tag);
        exp_t e;
        e.a = a; e.d = d; e.tag = tag;
        exp_q.push_back(e);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: pop the expected item and compare a quarter period after the edge
    always @(posedge clk) begin
        if (bus_rd) begin
            exp_t e;
            #(CLK_PERIOD/4);
            if (exp_q.size() == 0) begin
                chk("scoreboard underflow", bus_rdata, 16'hxxxx);
            end else begin
                e = exp_q.pop_front();
                chk(e.tag, bus_rdata, e.d);
            end
        end
    end

    function automatic logic [15:0] oe_model(input logic [15:0] d, o, l);
        return ~d & (~o | ~l);
    endfunction

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);

        // R1 reset state
        chk("R1 pad_oe", pad_oe, 16'h0000);
        chk("R1 irq", {15'd0, irq}, 16'h0000);
        bus_read(4'h0, 16'hFFFF, "R1 dir");
        bus_read(4'h4, 16'hFFFF, "R1 analog");
        bus_read(4'h2, 16'h0000, "R1 latch");
        bus_read(4'h3, 16'h0000, "R1 odc");
        bus_read(4'h5, 16'h0000, "R1 cne");
        bus_read(4'h6, 16'h0000, "R1 pu");
        bus_read(4'h7, 16'h0000, "R1 pd");
        bus_read(4'h8, 16'h0000, "R1 pend");

        // R2 register map and pull passthrough
        bus_write(4'h0, 16'hFF00);
        bus_write(4'h3, 16'h00F0);
        bus_write(4'h6, 16'h1234);
        bus_write(4'h7, 16'h4321);
        bus_read(4'h0, 16'hFF00, "R2 dir");
        bus_read(4'h3, 16'h00F0, "R2 odc");
        bus_read(4'h6, 16'h1234, "R2 pu");
        bus_read(4'h7, 16'h4321, "R2 pd");
        chk("R2 pad_pu", pad_pu, 16'h1234);
        chk("R2 pad_pd", pad_pd, 16'h4321);

        // R3 port write goes to latch; R4/R5 drive while still analog
        bus_write(4'h1, 16'hA5C3);
        bus_read(4'h2, 16'hA5C3, "R3 latch via port write");
        chk("R4 R5 pad_oe", pad_oe, oe_model(16'hFF00, 16'h00F0, 16'hA5C3));
        chk("R4 pad_out", pad_out, 16'hA5C3 & ~16'h00F0);
        pad_in = 16'h3C3C;
        wait_cyc(3);
        bus_read(4'h1, 16'h0000, "R3 R6 port read all analog");

        // R6 masked digital read
        bus_write(4'h4, 16'h0F00);
        bus_write(4'h2, 16'h0000);
        chk("R4 pad_out latch 0", pad_out, 16'h0000);
        bus_read(4'h4, 16'h0F00, "R2 analog");
        bus_read(4'h1, 16'h3C3C & ~16'h0F00, "R6 port read");
        chk("R6 pin_din", pin_din, 16'h3C3C & ~16'h0F00);
        pad_in = 16'h3C3D;
        wait_cyc(1);
        chk("R6 one stage not yet", pin_din, 16'h303C);
        wait_cyc(1);
        chk("R6 after sync", pin_din, 16'h303D);
        pad_in = 16'h3C3C;
        wait_cyc(4);

        // R7 unmapped
        bus_read(4'h9, 16'h0000, "R7 unmapped 9");
        bus_read(4'hF, 16'h0000, "R7 unmapped F");

        // R8 notification
        bus_write(4'h5, 16'h01FF);
        bus_read(4'h5, 16'h01FF, "R2 cne");
        bus_read(4'h8, 16'h0000, "R8 no event before edges");
        pad_in ^= 16'h0001;
        wait_cyc(5);
        bus_read(4'h8, 16'h0001, "R8 rise enabled");
        chk("R9 irq raised", {15'd0, irq}, 16'h0001);
        pad_in ^= 16'h1100;
        wait_cyc(5);
        bus_read(4'h8, 16'h0001, "R8 analog and disabled ignored");
        bus_write(4'h8, 16'h0001);
        wait_cyc(2);
        chk("R9 irq dropped", {15'd0, irq}, 16'h0000);
        bus_read(4'h8, 16'h0000, "R10 cleared");
        pad_in ^= 16'h0001;
        wait_cyc(5);
        bus_read(4'h8, 16'h0001, "R8 fall enabled");
        bus_write(4'h8, 16'hFFFE);
        bus_read(4'h8, 16'h0001, "R10 zero bits keep");
        bus_write(4'h8, 16'h0001);
        wait_cyc(2);
        bus_read(4'h8, 16'h0000, "R10 clear");

        // R11 set and clear in the same cycle
        pad_in ^= 16'h0002;
        wait_cyc(2);
        bus_write(4'h8, 16'h0002);
        bus_read(4'h8, 16'h0002, "R11 set wins");
        chk("R11 irq", {15'd0, irq}, 16'h0001);
        bus_write(4'h8, 16'h0002);
        wait_cyc(2);

        // R12 edges with the clock parked
        clk_run = 1'b0;
        #(CLK_PERIOD*2);
        pad_in ^= 16'h0004;
        #(CLK_PERIOD);
        pad_in ^= 16'h0004;
        #(CLK_PERIOD*2);
        clk_run = 1'b1;
        wait_cyc(6);
        bus_read(4'h8, 16'h0004, "R12 sleep edge");
        chk("R12 irq", {15'd0, irq}, 16'h0001);

        wait_cyc(3);
        if (exp_q.size() != 0) chk("scoreboard leftover", 16'(exp_q.size()), 16'h0000);
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule